// File: doc/BRIEF.md
# Video Output Compositor and Raster Generator

The block produces an 8-bit component digital video byte stream, one byte per clock, in the BT.656 style. Each line has an end-of-active-video timing code, a horizontal blanking run, a start-of-active-video timing code and an active run in the order Cb, Y, Cr, Y. Line length, blanking width, lines per frame, the split point between two fields and the vertical blanking depth come from configuration inputs. These settings support both interlaced and progressive rasters.

Active pixels merge two layers. The video layer arrives as separate luma and chroma planes. The overlay layer arrives as one packed word per pixel that holds alpha, Y, U and V. The block drives the pixel indices it needs on its outputs, and the fetch side returns the matching samples in the same cycle. The video layer can be stretched horizontally by two by repeating samples, while the overlay always stays at full resolution. The merge either blends the two layers by the overlay alpha or treats key-coloured overlay pixels as transparent.

Top module: `video_out_compositor`

## Requirements
- R1: Every timing code is the four bytes 0xFF, 0x00, 0x00, XY. The end-of-active code occupies line positions 0 to 3, and the start-of-active code starts at position 4 + cfg_hblank.
- R2: The XY byte is {1, F, V, H, V^H, F^H, F^V, F^V^H} from bit 7 down to bit 0. H is 1 in the end-of-active code and 0 in the start-of-active code.
- R3: Horizontal blanking bytes (cfg_hblank of them, an even count) alternate 0x80 at even line positions and 0x10 at odd ones.
- R4: A line is 8 + cfg_hblank + 2*cfg_hactive bytes long. Active byte 4k+j of a line carries Cb, Y, Cr, Y for j = 0..3, where bytes 0 to 2 belong to pixel 2k and byte 3 belongs to pixel 2k+1. Lines count 0 to cfg_vtotal-1 and then wrap.
- R5: With cfg_interlace set, F is 1 on lines at or above cfg_f0_lines and 0 below. With cfg_interlace clear, F is always 0. V is 1 on the first cfg_vblank lines of each field (or of the frame), and the active bytes of those lines carry the blanking pattern of R3.
- R6: With cfg_upscale clear, the luma index is the pixel number and the chroma index is the pair number. With cfg_upscale set, both indices are halved, so each luma sample and each Cb/Cr pair is used twice. ovl_idx is always the pixel number.
- R7: In blend mode (cfg_key_mode = 0), each component is (A*ovl + (255-A)*vid + 128) >> 8, with A taken from ovl_pix[31:24]. ovl_pix packs Y in bits [23:16], U in [15:8] and V in [7:0].
- R8: In key mode (cfg_key_mode = 1), a pixel whose overlay U and V each lie within cfg_key_tol of cfg_key_u and cfg_key_v shows the video component. Any other pixel shows the overlay component unchanged.
- R9: With cfg_ovl_en clear, active bytes carry the video layer alone.
- R10: Active data bytes are limited to the range 0x01 to 0xFE, so 0x00 becomes 0x01 and 0xFF becomes 0xFE.
- R11: While rst_n is low, bt_out is 0x10 and the raster is at line 0, position 0. The first byte after reset is the 0xFF that opens line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_hactive | input | HW | Active pixels per line (even) |
| cfg_hblank | input | HW | Horizontal blanking bytes (even) |
| cfg_vtotal | input | VW | Lines per frame |
| cfg_f0_lines | input | VW | Lines in the first field |
| cfg_vblank | input | VW | Vertical blanking lines per field |
| cfg_interlace | input | 1 | Two-field raster |
| cfg_upscale | input | 1 | Horizontal 2x stretch of the video layer |
| cfg_ovl_en | input | 1 | Overlay layer enable |
| cfg_key_mode | input | 1 | 0 blend, 1 chroma key |
| cfg_key_u | input | 8 | Key U value |
| cfg_key_v | input | 8 | Key V value |
| cfg_key_tol | input | 8 | Key tolerance |
| vid_yidx | output | HW | Video luma sample index |
| vid_cidx | output | HW | Video chroma pair index |
| vid_y | input | 8 | Video luma sample |
| vid_u | input | 8 | Video Cb sample |
| vid_v | input | 8 | Video Cr sample |
| ovl_idx | output | HW | Overlay pixel index |
| ovl_pix | input | 32 | Overlay pixel {A, Y, U, V} |
| bt_out | output | 8 | Output byte stream |

## Verification
The bench compares every byte of a full frame plus one wrapped line against a model built from the requirements. An error in line length or code placement therefore appears as a shifted stream. A wrong parity formula or a swapped F or V flag appears in the XY bytes of both fields, including the field-split line of the interlaced raster. Sample patterns include 0x00 and 0xFF values to catch missing clipping, and alpha values of 0 and 255 to catch rounding or weighting errors. Overlay chroma near the key at distances 0, 1 and 3 catches an off-by-one in the tolerance compare. The stretched run catches a design that halves only the luma index or also halves the overlay index.

// File: rtl/video_out_compositor.sv
module video_out_compositor #(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] cfg_hactive,
  input  logic [HW-1:0] cfg_hblank,
  input  logic [VW-1:0] cfg_vtotal,
  input  logic [VW-1:0] cfg_f0_lines,
  input  logic [VW-1:0] cfg_vblank,
  input  logic          cfg_interlace,
  input  logic          cfg_upscale,
  input  logic          cfg_ovl_en,
  input  logic          cfg_key_mode,
  input  logic [7:0]    cfg_key_u,
  input  logic [7:0]    cfg_key_v,
  input  logic [7:0]    cfg_key_tol,
  output logic [HW-1:0] vid_yidx,
  output logic [HW-1:0] vid_cidx,
  input  logic [7:0]    vid_y,
  input  logic [7:0]    vid_u,
  input  logic [7:0]    vid_v,
  output logic [HW-1:0] ovl_idx,
  input  logic [31:0]   ovl_pix,
  output logic [7:0]    bt_out
);

  localparam logic [7:0] BLANK_C = 8'h80;
  localparam logic [7:0] BLANK_Y = 8'h10;

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;

  wire [HW-1:0] sav_pos  = HW'(4) + cfg_hblank;
  wire [HW-1:0] act_pos  = sav_pos + HW'(4);
  wire [HW-1:0] line_end = act_pos + {cfg_hactive[HW-2:0], 1'b0} - HW'(1);
  wire          line_last = (hcnt == line_end);

  wire          fld   = cfg_interlace && (vcnt >= cfg_f0_lines);
  wire [VW-1:0] vfld  = fld ? vcnt - cfg_f0_lines : vcnt;
  wire          vbl   = vfld < cfg_vblank;

  wire          in_eav = hcnt < HW'(4);
  wire          in_sav = (hcnt >= sav_pos) && (hcnt < act_pos);
  wire          in_act = hcnt >= act_pos;
  wire [HW-1:0] sav_rel = hcnt - sav_pos;
  wire [1:0]    code_k  = in_eav ? hcnt[1:0] : sav_rel[1:0];
  wire          hbit    = in_eav;
  wire [7:0]    xy = {1'b1, fld, vbl, hbit, vbl ^ hbit, fld ^ hbit, fld ^ vbl, fld ^ vbl ^ hbit};

  wire [HW-1:0] aoff = hcnt - act_pos;
  wire [HW-3:0] pair = aoff[HW-1:2];
  wire [1:0]    sub  = aoff[1:0];
  wire [HW-2:0] px   = {pair, sub == 2'd3};

  assign ovl_idx  = {1'b0, px};
  assign vid_yidx = cfg_upscale ? {2'b0, px[HW-2:1]} : {1'b0, px};
  assign vid_cidx = cfg_upscale ? {3'b0, pair[HW-3:1]} : {2'b0, pair};

  wire [7:0] o_a = ovl_pix[31:24];
  wire [7:0] o_y = ovl_pix[23:16];
  wire [7:0] o_u = ovl_pix[15:8];
  wire [7:0] o_v = ovl_pix[7:0];

  wire [7:0] vcomp = (sub == 2'd0) ? vid_u : (sub == 2'd2) ? vid_v : vid_y;
  wire [7:0] ocomp = (sub == 2'd0) ? o_u   : (sub == 2'd2) ? o_v   : o_y;

  wire [15:0] mix = 16'(o_a) * 16'(ocomp) + 16'(8'd255 - o_a) * 16'(vcomp) + 16'd128;
  wire [7:0]  blended = mix[15:8];

  wire [7:0] du = (o_u >= cfg_key_u) ? o_u - cfg_key_u : cfg_key_u - o_u;
  wire [7:0] dv = (o_v >= cfg_key_v) ? o_v - cfg_key_v : cfg_key_v - o_v;
  wire       keyed = (du <= cfg_key_tol) && (dv <= cfg_key_tol);

  logic [7:0] merged, clipped, nxt;

  always_comb begin
    if (!cfg_ovl_en)       merged = vcomp;
    else if (cfg_key_mode) merged = keyed ? vcomp : ocomp;
    else                   merged = blended;
    if (merged == 8'h00)      clipped = 8'h01;
    else if (merged == 8'hFF) clipped = 8'hFE;
    else                      clipped = merged;
  end

  always_comb begin
    if (in_eav || in_sav) begin
      case (code_k)
        2'd0:    nxt = 8'hFF;
        2'd3:    nxt = xy;
        default: nxt = 8'h00;
      endcase
    end else if (in_act && !vbl) begin
      nxt = clipped;
    end else begin
      nxt = hcnt[0] ? BLANK_Y : BLANK_C;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt   <= '0;
      vcnt   <= '0;
      bt_out <= BLANK_Y;
    end else begin
      bt_out <= nxt;
      if (line_last) begin
        hcnt <= '0;
        vcnt <= (vcnt == cfg_vtotal - VW'(1)) ? '0 : vcnt + VW'(1);
      end else begin
        hcnt <= hcnt + HW'(1);
      end
    end
  end

endmodule

// File: rtl/video_out_compositor_chk.sv
module video_out_compositor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_interlace,
  input logic [7:0] bt_out
);

  // R1
  code_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bt_out == 8'hFF) |=> (bt_out == 8'h00));

  // R2
  xy_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bt_out, 3) == 8'hFF && $past(bt_out, 2) == 8'h00 && $past(bt_out) == 8'h00) |->
    (bt_out[7] && bt_out[3:0] == {bt_out[5] ^ bt_out[4], bt_out[6] ^ bt_out[4],
                                  bt_out[6] ^ bt_out[5], bt_out[6] ^ bt_out[5] ^ bt_out[4]}));

  // R5
  prog_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_interlace && $past(bt_out, 3) == 8'hFF && $past(bt_out, 2) == 8'h00 &&
     $past(bt_out) == 8'h00) |-> !bt_out[6]);

  // R10
  zero_only_in_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bt_out == 8'h00) |-> ($past(bt_out) == 8'hFF ||
                           ($past(bt_out) == 8'h00 && $past(bt_out, 2) == 8'hFF)));

  // R10
  ff_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bt_out == 8'hFF) |-> ($past(bt_out) != 8'hFF));

endmodule

bind video_out_compositor video_out_compositor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_interlace(cfg_interlace), .bt_out(bt_out)
);

// File: tb/video_out_compositor_test.sv
`timescale 1ns/100ps
module video_out_compositor_test;
  localparam int HW = 12;
  localparam int VW = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [HW-1:0] cfg_hactive = 12'd8, cfg_hblank = 12'd4;
  logic [VW-1:0] cfg_vtotal = 11'd10, cfg_f0_lines = 11'd5, cfg_vblank = 11'd2;
  logic cfg_interlace = 0, cfg_upscale = 0, cfg_ovl_en = 0, cfg_key_mode = 0;
  logic [7:0] cfg_key_u = 8'h41, cfg_key_v = 8'h50, cfg_key_tol = 8'd1;
  logic [HW-1:0] vid_yidx, vid_cidx, ovl_idx;
  logic [7:0] vid_y, vid_u, vid_v, bt_out;
  logic [31:0] ovl_pix;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  video_out_compositor uut (.*);

  function automatic logic [7:0] fy(int i); return 8'((i * 73) & 255); endfunction
  function automatic logic [7:0] fu(int i); return 8'((i * 29 + 200) & 255); endfunction
  function automatic logic [7:0] fv(int i); return 8'((i * 53 + 255) & 255); endfunction
  function automatic logic [31:0] fo(int i);
    logic [7:0] a, y, u, v;
    a = (i == 0) ? 8'd0 : (i == 1) ? 8'd255 : 8'((i * 61) & 255);
    y = 8'((255 - i * 11) & 255);
    u = (i % 4 < 2) ? 8'(8'h40 + i % 3) : 8'h90;
    v = (i % 3 == 2) ? 8'h53 : 8'h50;
    return {a, y, u, v};
  endfunction

  always_comb begin
    vid_y = fy(int'(vid_yidx));
    vid_u = fu(int'(vid_cidx));
    vid_v = fv(int'(vid_cidx));
    ovl_pix = fo(int'(ovl_idx));
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      if (fails < 20) $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(int h, int v, output string tag);
    int sav, act, vf, k, ao, pr, sb, px, yi, ci, d1, d2;
    bit f, vb, hh, key;
    logic [7:0] vc, oc, a, r;
    logic [31:0] ov;
    sav = 4 + int'(cfg_hblank); act = sav + 4;
    f = cfg_interlace && v >= int'(cfg_f0_lines);
    vf = f ? v - int'(cfg_f0_lines) : v;
    vb = vf < int'(cfg_vblank);
    if (h < 4 || (h >= sav && h < act)) begin
      hh = h < 4; k = hh ? h : h - sav;
      tag = (k == 3) ? "R2" : "R1";
      if (k == 0) return 8'hFF;
      if (k < 3) return 8'h00;
      return {1'b1, f, vb, hh, vb ^ hh, f ^ hh, f ^ vb, f ^ vb ^ hh};
    end
    if (h < act) begin tag = "R3"; return (h % 2 == 0) ? 8'h80 : 8'h10; end
    if (vb) begin tag = "R5"; return (h % 2 == 0) ? 8'h80 : 8'h10; end
    tag = "";
    ao = h - act; pr = ao / 4; sb = ao % 4; px = pr * 2 + (sb == 3 ? 1 : 0);
    yi = cfg_upscale ? px / 2 : px; ci = cfg_upscale ? pr / 2 : pr;
    vc = (sb == 0) ? fu(ci) : (sb == 2) ? fv(ci) : fy(yi);
    ov = fo(px); a = ov[31:24];
    oc = (sb == 0) ? ov[15:8] : (sb == 2) ? ov[7:0] : ov[23:16];
    d1 = int'(ov[15:8]) - int'(cfg_key_u); if (d1 < 0) d1 = -d1;
    d2 = int'(ov[7:0]) - int'(cfg_key_v); if (d2 < 0) d2 = -d2;
    key = d1 <= int'(cfg_key_tol) && d2 <= int'(cfg_key_tol);
    if (!cfg_ovl_en) r = vc;
    else if (cfg_key_mode) r = key ? vc : oc;
    else r = 8'((int'(a) * int'(oc) + (255 - int'(a)) * int'(vc) + 128) >> 8);
    if (r == 8'h00) r = 8'h01;
    if (r == 8'hFF) r = 8'hFE;
    return r;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    check("R11 reset output", bt_out, 8'h10);
    rst_n = 1;
  endtask

  task automatic run_frame(string atag);
    int h = 0, v = 0, len;
    string tag;
    logic [7:0] e;
    len = 8 + int'(cfg_hblank) + 2 * int'(cfg_hactive);
    do_reset();
    for (int n = 0; n < (int'(cfg_vtotal) + 1) * len; n++) begin
      @(negedge clk);
      e = exp_byte(h, v, tag);
      if (n == 0) check("R11 first byte", bt_out, 8'hFF);
      check(tag == "" ? atag : tag, bt_out, e);
      h++;
      if (h == len) begin h = 0; v = (v + 1) % int'(cfg_vtotal); end
    end
  endtask

  task automatic t_progressive_video();
    cfg_interlace = 0; cfg_upscale = 0; cfg_ovl_en = 0;
    run_frame("R4 R9 progressive video");
  endtask

  task automatic t_interlaced_upscale();
    cfg_interlace = 1; cfg_upscale = 1; cfg_ovl_en = 0;
    run_frame("R6 R5 interlaced upscale");
  endtask

  task automatic t_alpha_blend();
    cfg_interlace = 0; cfg_upscale = 0; cfg_ovl_en = 1; cfg_key_mode = 0;
    run_frame("R7 R10 alpha blend");
  endtask

  task automatic t_alpha_upscale();
    cfg_interlace = 1; cfg_upscale = 1; cfg_ovl_en = 1; cfg_key_mode = 0;
    run_frame("R6 R7 overlay full rate");
  endtask

  task automatic t_chroma_key();
    cfg_interlace = 0; cfg_upscale = 0; cfg_ovl_en = 1; cfg_key_mode = 1;
    cfg_key_tol = 8'd1;
    run_frame("R8 key tol 1");
    cfg_key_tol = 8'd3;
    run_frame("R8 key tol 3");
  endtask

  task automatic t_wide_blank();
    cfg_hblank = 12'd10; cfg_hactive = 12'd12; cfg_vblank = 11'd1;
    cfg_interlace = 1; cfg_upscale = 0; cfg_ovl_en = 0;
    run_frame("R4 R3 wide blanking");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_progressive_video();
    t_interlaced_upscale();
    t_alpha_blend();
    t_alpha_upscale();
    t_chroma_key();
    t_wide_blank();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule